// File: doc/BRIEF.md
# Next-PC Sequencer

This unit owns the program counter of a simple 32-bit in-order core and chooses, every clock, the address of the next instruction. It receives the decoded fields of the instruction at the current PC: a 6-bit opcode, a 6-bit function code, the 16-bit immediate and the 26-bit jump field. It also receives a register value for indirect jumps, an equality result from the register comparator, and a stall request.

With no control transfer, the PC moves to the following word. Conditional branches add a signed word offset to the already-incremented PC. Direct jumps splice a word index into the current 256 MiB region. Indirect jumps load a register value. The unit also drives the return address PC+4, which call instructions write back to the link register.

Top module: `npc_unit`

## Requirements
- R1: While rst_ni is low, pc_o is 0 and link_o is 4. The reset acts asynchronously.
- R2: On each unstalled clock edge, an instruction that is not a control transfer advances pc_o by 4. The increment wraps modulo 2^32. Opcode 0 with a function code other than 8 counts as such an instruction.
- R3: Opcode 4 (branch-if-equal) with eq_i=1 loads pc_o+4+(sign-extended imm_i × 4). A negative immediate moves backward.
- R4: Opcode 5 (branch-if-not-equal) with eq_i=0 loads the same branch target as R3.
- R5: A branch whose condition fails (opcode 4 with eq_i=0, or opcode 5 with eq_i=1) advances pc_o by 4.
- R6: Opcode 2 (jump) loads {bits 31..28 of pc_o+4, target_i, 2'b00}.
- R7: Opcode 3 (jump-and-link) loads the same target as R6, while link_o presents pc_o+4 as the return address during that cycle.
- R8: Opcode 0 with function code 8 (register jump) loads the full 32-bit rs_val_i.
- R9: While stall_i is high, pc_o holds its value and all instruction inputs are ignored.
- R10: link_o always equals pc_o+4 (modulo 2^32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | Hold the PC this cycle |
| opcode_i | input | 6 | Primary opcode of the current instruction |
| funct_i | input | 6 | Function code for opcode 0 |
| imm_i | input | 16 | Branch word offset, two's complement |
| target_i | input | 26 | Direct jump word index |
| rs_val_i | input | 32 | Register value for indirect jumps |
| eq_i | input | 1 | Compared registers are equal |
| pc_o | output | 32 | Current program counter |
| link_o | output | 32 | Return address, pc_o+4 |

## Verification
Any wrong select or target shows on pc_o one clock after the instruction that caused it. The error then persists in every later address, because every later target is built from the corrupted PC. A mis-sized offset or a misplaced splice shows as a PC that is off by a multiple of 4. A wrong condition polarity shows as a taken branch that should have fallen through, or as a missing jump. The vector walk chains each expected PC from the previous one, so a single bad step cascades into failures in the following checks. Wrapping at 2^32 is exercised, and so are negative offsets and upper PC bits that are not zero.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned OP_W = 6;
  localparam int unsigned FN_W = 6;

  localparam logic [OP_W-1:0] OP_SPECIAL = 6'd0;
  localparam logic [OP_W-1:0] OP_JMP     = 6'd2;
  localparam logic [OP_W-1:0] OP_JAL     = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ     = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE     = 6'd5;
  localparam logic [FN_W-1:0] FN_JR      = 6'd8;

  // one-hot next-PC source index
  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_JMP = 2'd2,
    SRC_REG = 2'd3
  } npc_src_e;

  localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [OP_W-1:0]    opcode_i,
  input  logic [FN_W-1:0]    funct_i,
  input  logic               eq_i,
  output logic [NUM_SRC-1:0] src_oh_o
);
  logic is_beq, is_bne, is_jmp, is_jr, br_taken;

  assign is_beq   = (opcode_i == OP_BEQ);
  assign is_bne   = (opcode_i == OP_BNE);
  assign is_jmp   = (opcode_i == OP_JMP) || (opcode_i == OP_JAL);
  assign is_jr    = (opcode_i == OP_SPECIAL) && (funct_i == FN_JR);
  assign br_taken = (is_beq && eq_i) || (is_bne && !eq_i);

  always_comb begin
    src_oh_o = '0;
    if (br_taken)    src_oh_o[SRC_BR]  = 1'b1;
    else if (is_jmp) src_oh_o[SRC_JMP] = 1'b1;
    else if (is_jr)  src_oh_o[SRC_REG] = 1'b1;
    else             src_oh_o[SRC_SEQ] = 1'b1;
  end

  // R2 R5: exactly one source selected every cycle
  a_r2_onehot_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(src_oh_o) == 1);
  // R5: a failing condition never selects the branch source
  a_r5_no_false_branch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((is_beq && !eq_i) || (is_bne && eq_i)) |-> src_oh_o[SRC_SEQ]);
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned TGT_W = 26
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  output logic [XLEN-1:0]  pc4_o,
  output logic [XLEN-1:0]  br_tgt_o,
  output logic [XLEN-1:0]  jmp_tgt_o
);
  localparam int unsigned SEXT_W = XLEN - IMM_W - 2;
  localparam int unsigned HI_W   = XLEN - TGT_W - 2;

  logic [XLEN-1:0] br_off;

  assign pc4_o     = pc_i + XLEN'(4);
  // word offset, sign-extended, relative to the incremented PC
  assign br_off    = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, 2'b00};
  assign br_tgt_o  = pc4_o + br_off;
  // region bits come from PC+4, not PC
  assign jmp_tgt_o = {pc4_o[XLEN-1 -: HI_W], target_i, 2'b00};
endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
  parameter int unsigned   XLEN     = 32,
  parameter logic [31:0]   RESET_PC = 32'h0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hold_i,
  input  logic [XLEN-1:0] next_i,
  output logic [XLEN-1:0] pc_o
);
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= XLEN'(RESET_PC);
    else if (!hold_i) pc_q <= next_i;
  end

  assign pc_o = pc_q;

  // R9: a held cycle leaves the PC untouched
  a_r9_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(pc_q));
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned IMM_W    = 16,
  parameter int unsigned TGT_W    = 26,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stall_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [FN_W-1:0]  funct_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [TGT_W-1:0] target_i,
  input  logic [XLEN-1:0]  rs_val_i,
  input  logic             eq_i,
  output logic [XLEN-1:0]  pc_o,
  output logic [XLEN-1:0]  link_o
);
  logic [NUM_SRC-1:0] src_oh;
  logic [XLEN-1:0]    pc, pc4, br_tgt, jmp_tgt, next_pc;
  logic [XLEN-1:0]    cand [NUM_SRC];

  npc_decode u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .funct_i  (funct_i),
    .eq_i     (eq_i),
    .src_oh_o (src_oh)
  );

  npc_target #(.XLEN(XLEN), .IMM_W(IMM_W), .TGT_W(TGT_W)) u_target (
    .pc_i      (pc),
    .imm_i     (imm_i),
    .target_i  (target_i),
    .pc4_o     (pc4),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  assign cand[SRC_SEQ] = pc4;
  assign cand[SRC_BR]  = br_tgt;
  assign cand[SRC_JMP] = jmp_tgt;
  assign cand[SRC_REG] = rs_val_i;

  // AND-OR mux over the one-hot select
  always_comb begin
    next_pc = '0;
    for (int i = 0; i < NUM_SRC; i++)
      next_pc |= cand[i] & {XLEN{src_oh[i]}};
  end

  npc_pcreg #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pcreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (stall_i),
    .next_i (next_pc),
    .pc_o   (pc)
  );

  assign pc_o   = pc;
  assign link_o = pc4;

  // R3: equal branch lands at PC+4 plus scaled offset
  a_r3_beq_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && opcode_i == OP_BEQ && eq_i) |=>
      pc_o == $past(pc_o) + XLEN'(4) +
              $past({{(XLEN-IMM_W-2){imm_i[IMM_W-1]}}, imm_i, 2'b00}));
  // R5: failed branch falls through
  a_r5_bne_fallthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && opcode_i == OP_BNE && eq_i) |=> pc_o == $past(pc_o) + XLEN'(4));
  // R8: register jump takes the operand verbatim
  a_r8_reg_jump: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && opcode_i == OP_SPECIAL && funct_i == FN_JR) |=> pc_o == $past(rs_val_i));
  // R6 R7: direct jumps keep the region of PC+4 and clear the byte bits
  a_r6_jump_region: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && (opcode_i == OP_JMP || opcode_i == OP_JAL)) |=>
      (pc_o[1:0] == 2'b00) && (pc_o[XLEN-1 -: 4] == $past(link_o[XLEN-1 -: 4])));
  // R10: return address is one word past the PC
  a_r10_link: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (link_o - pc_o) == XLEN'(4));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/1ps
module npc_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall;
  logic [5:0]  op, fn;
  logic [15:0] imm;
  logic [25:0] tgt;
  logic [31:0] rs;
  logic        eq;
  logic [31:0] pc, link;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  npc_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stall_i(stall), .opcode_i(op), .funct_i(fn),
    .imm_i(imm), .target_i(tgt), .rs_val_i(rs), .eq_i(eq), .pc_o(pc), .link_o(link)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [5:0]  fn;
    logic [15:0] imm;
    logic [25:0] tgt;
    logic [31:0] rs;
    logic        eq;
    logic        st;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{6'd8, 6'd0,  16'd0,      26'd0,     32'd0,          1'b0, 1'b0, 32'd4,          4'd2}, // R2 plain op
    '{6'd0, 6'd32, 16'd0,      26'd0,     32'hDEAD_BEE0,  1'b0, 1'b0, 32'd8,          4'd2}, // R2 opcode 0, funct!=8
    '{6'd4, 6'd0,  16'd25,     26'd0,     32'd0,          1'b1, 1'b0, 32'd112,        4'd3}, // R3 +25 words
    '{6'd4, 6'd0,  16'd25,     26'd0,     32'd0,          1'b0, 1'b0, 32'd116,        4'd5}, // R5 beq fails
    '{6'd5, 6'd0,  16'd3,      26'd0,     32'd0,          1'b0, 1'b0, 32'd132,        4'd4}, // R4 bne taken
    '{6'd5, 6'd0,  16'd3,      26'd0,     32'd0,          1'b1, 1'b0, 32'd136,        4'd5}, // R5 bne fails
    '{6'd4, 6'd0,  16'hFFFE,   26'd0,     32'd0,          1'b1, 1'b0, 32'd132,        4'd3}, // R3 backward
    '{6'd2, 6'd0,  16'd0,      26'd2500,  32'd0,          1'b0, 1'b0, 32'd10000,      4'd6}, // R6 word index
    '{6'd2, 6'd0,  16'd0,      26'd7,     32'd0,          1'b0, 1'b1, 32'd10000,      4'd9}, // R9 stalled jump
    '{6'd3, 6'd0,  16'd0,      26'h100,   32'd0,          1'b0, 1'b0, 32'd1024,       4'd7}, // R7 call target
    '{6'd0, 6'd8,  16'd0,      26'd0,     32'h8000_0000,  1'b0, 1'b0, 32'h8000_0000,  4'd8}, // R8 reg jump
    '{6'd2, 6'd0,  16'd0,      26'd5,     32'd0,          1'b0, 1'b0, 32'h8000_0014,  4'd6}, // R6 upper bits kept
    '{6'd0, 6'd8,  16'd0,      26'd0,     32'd0,          1'b0, 1'b1, 32'h8000_0014,  4'd9}, // R9 stalled reg jump
    '{6'd0, 6'd8,  16'd0,      26'd0,     32'hFFFF_FFFC,  1'b0, 1'b0, 32'hFFFF_FFFC,  4'd8}, // R8 top word
    '{6'd8, 6'd0,  16'd0,      26'd0,     32'd0,          1'b0, 1'b0, 32'd0,          4'd2}, // R2 wrap
    '{6'd5, 6'd0,  16'h8000,   26'd0,     32'd0,          1'b0, 1'b0, 32'hFFFE_0004,  4'd4}  // R4 most negative
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stall = 1'b0; op = 6'd8; fn = '0; imm = '0; tgt = '0; rs = '0; eq = 1'b0;
    repeat (3) @(negedge clk);
    check(pc, 32'd0, 1, "reset pc");      // R1
    check(link, 32'd4, 1, "reset link");  // R1
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      op = VECS[i].op; fn = VECS[i].fn; imm = VECS[i].imm; tgt = VECS[i].tgt;
      rs = VECS[i].rs; eq = VECS[i].eq; stall = VECS[i].st;
      if (VECS[i].req == 4'd7) check(link, pc + 32'd4, 7, "call return address");  // R7
      @(negedge clk);
      check(pc, VECS[i].exp, VECS[i].req, $sformatf("vector %0d pc", i));
      check(link, VECS[i].exp + 32'd4, 10, $sformatf("vector %0d link", i));  // R10
    end

    // R9: several stalled cycles with a jump presented
    stall = 1'b1; op = 6'd2; tgt = 26'h3FF_FFFF;
    repeat (3) @(negedge clk);
    check(pc, 32'hFFFE_0004, 9, "multi-cycle stall");

    // R1: asynchronous reset mid-run, between edges
    stall = 1'b0; op = 6'd8;
    #2 rst_n = 1'b0;
    #1 check(pc, 32'd0, 1, "async reset pc");
    check(link, 32'd4, 1, "async reset link");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pc, 32'd4, 2, "first step after reset");  // R2

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule